// File: doc/BRIEF.md
# Super-Rate Payload Mapping Control Unit

This block runs on the container byte clock and turns a continuous stream of 8-bit data bytes into the payload bytes of a 9-row by 270-column synchronous frame. It keeps its own frame position, walking the columns and rows. For each payload position it works out the byte type and builds the outgoing byte from a 24-bit assembly ring. Input bytes are written into the ring through a sliding 8-bit write window. Output bytes are taken through a sliding 8-bit read window that moves by 0, 6, 7 or 8 bits, depending on the type of the byte.

The first ten columns of every row carry section and path overhead. The block emits zero there and uses no stream bits. The remaining 260 columns form 20 blocks of 13 bytes. Byte 0 of a block is the block type byte: a control byte in blocks 0 to 4, the first stuff-opportunity byte in block 10, the second stuff-opportunity byte in block 15, and a reserved byte in every other block. Bytes 1 to 11 are full information bytes, and byte 12 carries only six information bits. A per-row justification flag decides two things: whether the stuff bit of the row carries data, and the value of the five control bits. Reserved bytes carry an auxiliary byte channel.

The upstream elasticity buffer behaves as a show-ahead source. Its current byte is taken at the clock edge of any cycle in which `eb_next` is high.

Top module: `srm_map_ctrl`

## Requirements
- R1: `pay_col` runs 0..269 and wraps to 0, with `pay_row` stepping 0..8 and then wrapping. `pay_frame` is 1 only for row 0, column 0. All `pay_*` outputs describe the position handled at the previous clock edge.
- R2: `pay_spe` is 0 for columns 0-9 and 1 for columns 10-269. In overhead columns `pay_byte` is 0 and no stream bits are used.
- R3: The payload column is p = column-10, its block is p/13 and its byte index is p%13. Byte indices 1-11 output the next 8 stream bits, first bit in bit 7, and use up 8 bits. The stream is the input bytes in order, each taken MSB first.
- R4: Byte index 12 outputs the next 8 stream bits but uses up only 6, so its last two bits open the following byte again.
- R5: Byte index 0 of blocks 0-4 is a control byte. Bits 7:2 are the next six stream bits, bit 1 is the row's justification flag, and bit 0 is 0. It uses up 6 bits.
- R6: Byte index 0 of block 10 outputs the next 8 stream bits. It uses up 8 bits when the row flag is 0 (stuff bit carries data) and 7 bits when the flag is 1.
- R7: Byte index 0 of block 15 outputs the next 8 stream bits. It uses up 7 bits when the row flag is 0 and 6 bits when it is 1.
- R8: Byte index 0 of every other block outputs `aux_byte` and uses no stream bits. `aux_rd` is 1 in exactly the cycle in which such a byte is taken.
- R9: `just_dummy` is sampled only in the cycle that handles column 0 of a row, and it stays in force for that whole row. Changes in other columns have no effect.
- R10: `eb_next` is 1 when the ring, after this cycle's read advance, has 8 or more free bits out of 24. The ring never holds more than 24 bits, and it holds at least 8 whenever a payload byte is built. After reset `eb_next` reads 1, 1, 1, 0 over the first four columns.
- R11: While `rst_n` is low, all `pay_*` outputs and `aux_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Container byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eb_byte | input | 8 | Current byte offered by the elasticity buffer |
| eb_next | output | 1 | Take `eb_byte` at this edge |
| just_dummy | input | 1 | 1: the stuff bit of the row is a dummy; 0: it carries data |
| aux_byte | input | 8 | Auxiliary channel byte |
| aux_rd | output | 1 | `aux_byte` is taken at this edge |
| pay_byte | output | 8 | Built payload byte |
| pay_row | output | 4 | Row of `pay_byte` |
| pay_col | output | 9 | Column of `pay_byte` |
| pay_frame | output | 1 | First byte of the frame |
| pay_spe | output | 1 | `pay_byte` lies in the payload area |

## Verification
The bench rebuilds the expected bit stream from the bytes it hands over, and tracks its own read offset through every byte type. A wrong advance for the six-bit byte, the control byte or either stuff byte shifts every later byte, so the fault shows up as a run of mismatches. Rows with all-data, all-dummy and alternating flags exercise both advances of each stuff byte. The alternating run also flips `just_dummy` in every cycle away from column 0, so a design that samples the flag anywhere else corrupts control bits and stuff advances. A request rule that fetches too late starves the window and garbles data. One that fetches too early overruns the ring. The startup request pattern and a final check of the fill level catch either error.

// File: rtl/srm_pkg.sv
package srm_pkg;

  localparam int SRM_BYTE_W = 8;
  localparam int SRM_ADV_W  = $clog2(SRM_BYTE_W + 1);

  typedef enum logic [2:0] {
    BK_OH    = 3'd0,
    BK_CTRL  = 3'd1,
    BK_S1    = 3'd2,
    BK_S2    = 3'd3,
    BK_RSV   = 3'd4,
    BK_INFO  = 3'd5,
    BK_INFO6 = 3'd6
  } bkind_e;

  // Read-window advance in bits for one byte type; dummy=1 means the
  // row's stuff bit carries no data.
  function automatic logic [SRM_ADV_W-1:0] read_advance(bkind_e kind, logic dummy);
    logic [SRM_ADV_W-1:0] a;
    case (kind)
      BK_INFO:  a = SRM_ADV_W'(SRM_BYTE_W);
      BK_INFO6: a = SRM_ADV_W'(SRM_BYTE_W - 2);
      BK_CTRL:  a = SRM_ADV_W'(SRM_BYTE_W - 2);
      BK_S1:    a = dummy ? SRM_ADV_W'(SRM_BYTE_W - 1) : SRM_ADV_W'(SRM_BYTE_W);
      BK_S2:    a = dummy ? SRM_ADV_W'(SRM_BYTE_W - 2) : SRM_ADV_W'(SRM_BYTE_W - 1);
      default:  a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/srm_frame_pos.sv
module srm_frame_pos
  import srm_pkg::*;
#(
  parameter int ROWS      = 9,
  parameter int COLS      = 270,
  parameter int OH_COLS   = 10,
  parameter int BLK_LEN   = 13,
  parameter int N_BLKS    = 20,
  parameter int CTRL_BLKS = 5,
  parameter int S1_BLK    = 10,
  parameter int S2_BLK    = 15,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dummy_in,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             frame_start,
  output logic             in_spe,
  output bkind_e           kind,
  output logic             row_dummy
);

  localparam int BLK_W  = $clog2(N_BLKS + 1);
  localparam int BPOS_W = $clog2(BLK_LEN);

  logic [BLK_W-1:0]  blk_q;
  logic [BPOS_W-1:0] bpos_q;
  logic              row_start;
  logic              col_last;
  logic              row_last;

  assign row_start   = (col_q == '0);
  assign col_last    = (col_q == COL_W'(COLS - 1));
  assign row_last    = (row_q == ROW_W'(ROWS - 1));
  assign frame_start = row_start && (row_q == '0);
  assign in_spe      = (col_q >= COL_W'(OH_COLS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (col_last) begin
      col_q <= '0;
      row_q <= row_last ? '0 : row_q + 1'b1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  // Block counters: cleared on the last overhead column, stepped in payload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      bpos_q <= '0;
    end else if (col_q == COL_W'(OH_COLS - 1)) begin
      blk_q  <= '0;
      bpos_q <= '0;
    end else if (in_spe) begin
      if (bpos_q == BPOS_W'(BLK_LEN - 1)) begin
        bpos_q <= '0;
        blk_q  <= blk_q + 1'b1;
      end else begin
        bpos_q <= bpos_q + 1'b1;
      end
    end
  end

  // Justification flag latched once per row.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         row_dummy <= 1'b0;
    else if (row_start) row_dummy <= dummy_in;
  end

  always_comb begin
    if (!in_spe)                            kind = BK_OH;
    else if (bpos_q == '0) begin
      if (blk_q < BLK_W'(CTRL_BLKS))        kind = BK_CTRL;
      else if (blk_q == BLK_W'(S1_BLK))     kind = BK_S1;
      else if (blk_q == BLK_W'(S2_BLK))     kind = BK_S2;
      else                                  kind = BK_RSV;
    end
    else if (bpos_q == BPOS_W'(BLK_LEN - 1)) kind = BK_INFO6;
    else                                     kind = BK_INFO;
  end

endmodule

// File: rtl/srm_asm_ring.sv
module srm_asm_ring
  import srm_pkg::*;
#(
  parameter int N         = 24,
  parameter int W         = SRM_BYTE_W,
  localparam int ADV_W    = $clog2(W + 1),
  localparam int FILL_W   = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADV_W-1:0]  adv,
  input  logic [W-1:0]      wr_byte,
  output logic              wr_take,
  output logic [W-1:0]      window,
  output logic [FILL_W-1:0] fill
);

  localparam int PTR_W = $clog2(N);

  logic [N-1:0]     ring_q;
  logic [PTR_W-1:0] rp_q;
  logic [PTR_W-1:0] wp_q;
  logic [FILL_W:0]  left_after;

  function automatic logic [PTR_W-1:0] wrap_idx(int v);
    return PTR_W'((v >= N) ? v - N : v);
  endfunction

  // Bits still held once this cycle's read advance is applied.
  assign left_after = {1'b0, fill} - (FILL_W + 1)'(adv);
  assign wr_take    = (left_after <= (FILL_W + 1)'(N - W));

  always_comb begin
    for (int i = 0; i < W; i++) begin
      window[W-1-i] = ring_q[wrap_idx(int'(rp_q) + i)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= '0;
      rp_q   <= '0;
      wp_q   <= '0;
      fill   <= '0;
    end else begin
      if (wr_take) begin
        for (int i = 0; i < W; i++) begin
          ring_q[wrap_idx(int'(wp_q) + i)] <= wr_byte[W-1-i];
        end
        wp_q <= wrap_idx(int'(wp_q) + W);
      end
      rp_q <= wrap_idx(int'(rp_q) + int'(adv));
      fill <= FILL_W'(int'(left_after) + (wr_take ? W : 0));
    end
  end

endmodule

// File: rtl/srm_byte_fmt.sv
module srm_byte_fmt
  import srm_pkg::*;
#(
  parameter int W     = SRM_BYTE_W,
  parameter int ROW_W = 4,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bkind_e           kind,
  input  logic [W-1:0]     window,
  input  logic             row_dummy,
  input  logic [W-1:0]     aux_in,
  input  logic [ROW_W-1:0] row_in,
  input  logic [COL_W-1:0] col_in,
  input  logic             frame_in,
  input  logic             spe_in,
  output logic             aux_rd,
  output logic [W-1:0]     byte_q,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             frame_q,
  output logic             spe_q
);

  logic [W-1:0] byte_d;

  // Control byte: six stream bits, the row flag, then a zero overhead bit.
  function automatic logic [W-1:0] ctrl_byte(logic [W-1:0] win, logic flag);
    return {win[W-1:2], flag, 1'b0};
  endfunction

  assign aux_rd = (kind == BK_RSV);

  always_comb begin
    case (kind)
      BK_OH:   byte_d = '0;
      BK_CTRL: byte_d = ctrl_byte(window, row_dummy);
      BK_RSV:  byte_d = aux_in;
      default: byte_d = window;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      frame_q <= 1'b0;
      spe_q   <= 1'b0;
    end else begin
      byte_q  <= byte_d;
      row_q   <= row_in;
      col_q   <= col_in;
      frame_q <= frame_in;
      spe_q   <= spe_in;
    end
  end

endmodule

// File: rtl/srm_map_ctrl.sv
module srm_map_ctrl
  import srm_pkg::*;
#(
  parameter int ROWS      = 9,
  parameter int COLS      = 270,
  parameter int OH_COLS   = 10,
  parameter int BLK_LEN   = 13,
  parameter int N_BLKS    = 20,
  parameter int CTRL_BLKS = 5,
  parameter int S1_BLK    = 10,
  parameter int S2_BLK    = 15,
  parameter int BUF_BITS  = 24,
  parameter int BYTE_W    = SRM_BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BYTE_W-1:0]         eb_byte,
  output logic                      eb_next,
  input  logic                      just_dummy,
  input  logic [BYTE_W-1:0]         aux_byte,
  output logic                      aux_rd,
  output logic [BYTE_W-1:0]         pay_byte,
  output logic [$clog2(ROWS)-1:0]   pay_row,
  output logic [$clog2(COLS)-1:0]   pay_col,
  output logic                      pay_frame,
  output logic                      pay_spe
);

  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int ADV_W  = $clog2(BYTE_W + 1);
  localparam int FILL_W = $clog2(BUF_BITS + 1);

  logic [ROW_W-1:0]  pos_row;
  logic [COL_W-1:0]  pos_col;
  logic              pos_frame;
  logic              pos_spe;
  bkind_e            pos_kind;
  logic              row_dummy;
  logic [ADV_W-1:0]  rd_adv;
  logic [BYTE_W-1:0] rd_window;
  logic [FILL_W-1:0] ring_fill;

  assign rd_adv = ADV_W'(read_advance(pos_kind, row_dummy));

  srm_frame_pos #(
    .ROWS(ROWS), .COLS(COLS), .OH_COLS(OH_COLS), .BLK_LEN(BLK_LEN),
    .N_BLKS(N_BLKS), .CTRL_BLKS(CTRL_BLKS), .S1_BLK(S1_BLK), .S2_BLK(S2_BLK)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .dummy_in(just_dummy),
    .row_q(pos_row), .col_q(pos_col), .frame_start(pos_frame),
    .in_spe(pos_spe), .kind(pos_kind), .row_dummy(row_dummy)
  );

  srm_asm_ring #(.N(BUF_BITS), .W(BYTE_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(rd_adv), .wr_byte(eb_byte),
    .wr_take(eb_next), .window(rd_window), .fill(ring_fill)
  );

  srm_byte_fmt #(.W(BYTE_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .kind(pos_kind), .window(rd_window),
    .row_dummy(row_dummy), .aux_in(aux_byte), .row_in(pos_row),
    .col_in(pos_col), .frame_in(pos_frame), .spe_in(pos_spe),
    .aux_rd(aux_rd), .byte_q(pay_byte), .row_q(pay_row), .col_q(pay_col),
    .frame_q(pay_frame), .spe_q(pay_spe)
  );

endmodule

// File: rtl/srm_map_chk.sv
module srm_map_chk #(
  parameter int ROWS     = 9,
  parameter int COLS     = 270,
  parameter int BUF_BITS = 24,
  parameter int BYTE_W   = 8,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int ADV_W   = $clog2(BYTE_W + 1),
  localparam int FILL_W  = $clog2(BUF_BITS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FILL_W-1:0] fill,
  input logic              in_spe,
  input logic              aux_rd,
  input logic [ADV_W-1:0]  adv,
  input logic [COL_W-1:0]  col_int,
  input logic              row_dummy,
  input logic [BYTE_W-1:0] pay_byte,
  input logic [ROW_W-1:0]  pay_row,
  input logic [COL_W-1:0]  pay_col,
  input logic              pay_frame,
  input logic              pay_spe
);

  // R10
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(BUF_BITS));

  // R10
  win_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_spe |-> (fill >= FILL_W'(BYTE_W)));

  // R8
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rd |-> (adv == '0));

  // R1
  frame_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_frame |-> (pay_row == '0 && pay_col == '0));

  // R1
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_col == COL_W'(COLS - 1)) |=> (pay_col == '0));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pay_spe |-> (pay_byte == '0));

  // R9
  row_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_int != '0) |=> $stable(row_dummy));

endmodule

bind srm_map_ctrl srm_map_chk #(
  .ROWS(ROWS), .COLS(COLS), .BUF_BITS(BUF_BITS), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fill(ring_fill), .in_spe(pos_spe),
  .aux_rd(aux_rd), .adv(rd_adv), .col_int(pos_col), .row_dummy(row_dummy),
  .pay_byte(pay_byte), .pay_row(pay_row), .pay_col(pay_col),
  .pay_frame(pay_frame), .pay_spe(pay_spe)
);

// File: tb/tb_srm_map_ctrl.sv
module tb_srm_map_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] eb_byte = '0;
  logic       eb_next;
  logic       just_dummy = 1'b0;
  logic [7:0] aux_byte = '0;
  logic       aux_rd;
  logic [7:0] pay_byte;
  logic [3:0] pay_row;
  logic [8:0] pay_col;
  logic       pay_frame;
  logic       pay_spe;

  always #4 clk = ~clk;

  srm_map_ctrl dut (
    .clk(clk), .rst_n(rst_n), .eb_byte(eb_byte), .eb_next(eb_next),
    .just_dummy(just_dummy), .aux_byte(aux_byte), .aux_rd(aux_rd),
    .pay_byte(pay_byte), .pay_row(pay_row), .pay_col(pay_col),
    .pay_frame(pay_frame), .pay_spe(pay_spe)
  );

  int n_cmp = 0, n_bad = 0;
  int seed, mode, cnt, acnt, rbit, mrow, mcol, fct, since_rst;
  bit pend_eb, pend_aux, noise, mjst;
  int e_byte, e_row, e_col, e_frame, e_spe;
  string e_req;

  function automatic logic [7:0] gen(int k);
    return 8'((k * 37 + seed * 11 + (k >> 4)) & 255);
  endfunction

  function automatic logic [7:0] agen(int k);
    return 8'((k * 53 + 200 + seed) & 255);
  endfunction

  function automatic logic [7:0] swin(int b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = gen((b + i) / 8);
      r[7-i] = v[7 - ((b + i) % 8)];
    end
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (model row %0d col %0d)",
               req, act, exp, mrow, mcol);
    end
  endtask

  // Drive inputs for the position handled at the next edge and predict it.
  task automatic prep();
    int k, p, blk, q, adv, pat;
    logic [7:0] w;
    pat = (mode == 0) ? 0 : (mode == 1) ? 1 : ((mrow + fct) % 2);
    noise = ~noise;
    if (mcol == 0) begin
      just_dummy = pat[0];
      mjst = pat[0];
    end else begin
      just_dummy = (mode == 2) ? (pat[0] ^ noise) : pat[0];
    end
    eb_byte  = gen(cnt);
    aux_byte = agen(acnt);
    if (mcol < 10) k = 0;
    else begin
      p = mcol - 10; blk = p / 13; q = p % 13;
      if (q == 0) k = (blk < 5) ? 1 : (blk == 10) ? 2 : (blk == 15) ? 3 : 4;
      else if (q == 12) k = 6;
      else k = 5;
    end
    if (since_rst < 4) chk("R10", int'(eb_next), (since_rst < 3) ? 1 : 0);
    chk("R8", int'(aux_rd), (k == 4) ? 1 : 0);
    pend_eb  = eb_next;
    pend_aux = (k == 4);
    w = swin(rbit);
    case (k)
      0: begin e_byte = 0; adv = 0; e_req = "R2"; end
      1: begin e_byte = {w[7:2], mjst, 1'b0}; adv = 6;
               e_req = (mode == 2) ? "R5 R9" : "R5"; end
      2: begin e_byte = w; adv = mjst ? 7 : 8; e_req = (mode == 2) ? "R6 R9" : "R6"; end
      3: begin e_byte = w; adv = mjst ? 6 : 7; e_req = (mode == 2) ? "R7 R9" : "R7"; end
      4: begin e_byte = agen(acnt); adv = 0; e_req = "R8"; end
      5: begin e_byte = w; adv = 8; e_req = "R3"; end
      default: begin e_byte = w; adv = 6; e_req = "R4"; end
    endcase
    e_row = mrow; e_col = mcol;
    e_frame = (mrow == 0 && mcol == 0) ? 1 : 0;
    e_spe = (mcol >= 10) ? 1 : 0;
    rbit += adv;
    if (mcol == 269) begin
      mcol = 0;
      if (mrow == 8) begin mrow = 0; fct++; end else mrow++;
    end else mcol++;
    since_rst++;
  endtask

  // After the edge: account for taken bytes and compare registered outputs.
  task automatic post();
    if (pend_eb) cnt++;
    if (pend_aux) acnt++;
    chk(e_req, int'(pay_byte), e_byte);
    chk("R1", int'(pay_row), e_row);
    chk("R1", int'(pay_col), e_col);
    chk("R1", int'(pay_frame), e_frame);
    chk("R2", int'(pay_spe), e_spe);
  endtask

  task automatic do_reset(int s, int m);
    @(negedge clk);
    rst_n = 1'b0;
    seed = s; mode = m;
    cnt = 0; acnt = 0; rbit = 0; mrow = 0; mcol = 0; fct = 0; since_rst = 0;
    noise = 1'b0; mjst = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", int'(pay_byte), 0);
    chk("R11", int'(pay_frame), 0);
    chk("R11", int'(pay_spe), 0);
    chk("R11", int'(aux_rd), 0);
    chk("R11", int'(pay_col), 0);
    chk("R11", int'(pay_row), 0);
    rst_n = 1'b1;
    prep();
  endtask

  task automatic run_frames(int frames);
    int n;
    int fillm;
    n = frames * 9 * 270;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      post();
      if (i < n - 1) prep();
    end
    fillm = cnt * 8 - rbit;
    // R10 ring level stays within 8..24 bits
    chk("R10", (fillm >= 8 && fillm <= 24) ? 1 : 0, 1);
  endtask

  // R3 R4 R5 R6 R7 R8: every row carries data in the stuff bit
  task automatic t_data_rows();
    do_reset(1, 0);
    run_frames(2);
  endtask

  // R5 R6 R7: every row marks the stuff bit as a dummy
  task automatic t_dummy_rows();
    do_reset(5, 1);
    run_frames(2);
  endtask

  // R9: flag alternates by row and toggles mid-row
  task automatic t_mixed_rows();
    do_reset(9, 2);
    run_frames(2);
  endtask

  initial begin
    t_data_rows();
    t_dummy_rows();
    t_mixed_rows();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule